// File: doc/BRIEF.md
# Supervisor Trap Value Capture Unit

This block owns the supervisor trap value register. When the core takes a trap, the block looks at the exception cause and loads one of three things: a faulting virtual address, the right-justified bits of an offending instruction, or zero. A per-cause enable mask lets the platform force zero for any cause that would otherwise record something informative. One example is a breakpoint raised by a software breakpoint instruction, where the exception PC already identifies the instruction.

Every value entering the register passes through one legalization step. This applies to trap captures and to software CSR writes alike. Canonical virtual addresses (bits 63..39 all equal to bit 38) are kept unchanged. A non-canonical address keeps bits 38..0, and bits 63..39 are filled with the inverse of bit 38. The result is still invalid, but the register can hold it in 40 bits of state. Captured instruction bits are at most 32 bits wide, so they always fall inside the canonical range.

Which cause codes exist, delegation, exception PC generation and address translation are handled by neighbouring logic. The exception PC is not produced here. For a multi-part access it still points at the first byte of the instruction.

Top module: `stval_capture`

## Requirements
- R1: After reset the register reads as zero, both at the first release of reset and after a reset applied later in operation.
- R2: A trap with cause 0, 1, 3, 4, 5, 6, 7, 12, 13 or 15 whose mask bit is set loads `fault_va_i`, and the value reads back on `csr_rdata_o` one clock after the strobe. When `part_valid_i` is low, this includes the fault causes.
- R3: For the fault causes 1, 5, 7, 12, 13 and 15 with `part_valid_i` high, `part_va_i` is loaded instead. For causes 0, 3, 4 and 6, `part_valid_i` has no effect.
- R4: A trap with cause 2 (illegal instruction) whose mask bit is set, with `insn_len32_i` high, loads `insn_i` zero-extended to 64 bits.
- R5: For cause 2 with `insn_len32_i` low, only `insn_i[15:0]` is kept, and bits 63..16 read as zero.
- R6: Any other cause loads zero. This covers 8 to 11, 14 and every code of 16 or above.
- R7: For a cause below 16 whose bit in `info_en_i` is clear, the trap loads zero whatever its address or instruction inputs are.
- R8: A non-canonical captured address is stored as bits 38..0 unchanged, with bits 63..39 set to the inverse of bit 38. A canonical address is stored unchanged.
- R9: A CSR write with no trap in the same cycle stores `csr_wdata_i` after the legalization of R8. The value reads back one clock later.
- R10: When a trap strobe and a CSR write fall in the same cycle, only the trap value is stored.
- R11: With neither a trap nor a CSR write, the register holds its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Trap taken this cycle |
| cause_i | input | 5 | Exception cause code |
| fault_va_i | input | 64 | Faulting virtual address |
| part_va_i | input | 64 | Address of the faulting portion of a multi-part access |
| part_valid_i | input | 1 | `part_va_i` applies to this trap |
| insn_i | input | 32 | Raw instruction bits, right-aligned |
| insn_len32_i | input | 1 | 1: 32-bit instruction, 0: 16-bit instruction |
| info_en_i | input | 16 | Per-cause enable for informative values |
| csr_we_i | input | 1 | Software write strobe |
| csr_wdata_i | input | 64 | Software write data |
| csr_rdata_o | output | 64 | Current register value |

## Verification
The register is the only state on the path. A trap or a CSR write presented before a rising edge is visible on `csr_rdata_o` right after that edge, so every result is due exactly one cycle after its strobe. The bench changes inputs on the falling edge, leaves the strobe up for one rising edge, and then samples the output at the next falling edge, when the captured value has settled. Hold checks span several idle cycles, with the data inputs changing while both strobes stay low.

// File: rtl/stval_pkg.sv
package stval_pkg;
  // Exception cause codes the selector distinguishes.
  localparam int C_INSN_MISALIGN = 0;
  localparam int C_INSN_ACCESS   = 1;
  localparam int C_ILLEGAL       = 2;
  localparam int C_BREAK         = 3;
  localparam int C_LOAD_MISALIGN = 4;
  localparam int C_LOAD_ACCESS   = 5;
  localparam int C_STORE_MISALIGN= 6;
  localparam int C_STORE_ACCESS  = 7;
  localparam int C_INSN_PAGE     = 12;
  localparam int C_LOAD_PAGE     = 13;
  localparam int C_STORE_PAGE    = 15;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ADDR = 2'd1,
    SRC_PART = 2'd2,
    SRC_INSN = 2'd3
  } src_e;
endpackage

// File: rtl/stval_src_sel.sv
module stval_src_sel
  import stval_pkg::*;
#(
  parameter int CAUSE_W = 5,
  parameter int NCAUSE  = 16
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [NCAUSE-1:0]  info_en_i,
  input  logic               part_valid_i,
  output src_e               src_o
);
  localparam int IDX_W = $clog2(NCAUSE);

  int   c;
  logic in_range, enabled, is_addr, is_fault, is_ill;

  always_comb begin
    c        = int'(cause_i);
    in_range = (c < NCAUSE);
    enabled  = in_range && info_en_i[cause_i[IDX_W-1:0]];
    is_fault = (c == C_INSN_ACCESS) || (c == C_LOAD_ACCESS) ||
               (c == C_STORE_ACCESS) || (c == C_INSN_PAGE) ||
               (c == C_LOAD_PAGE) || (c == C_STORE_PAGE);
    is_addr  = is_fault || (c == C_INSN_MISALIGN) || (c == C_BREAK) ||
               (c == C_LOAD_MISALIGN) || (c == C_STORE_MISALIGN);
    is_ill   = (c == C_ILLEGAL);

    if (!enabled)                      src_o = SRC_ZERO;  // R7
    else if (is_ill)                   src_o = SRC_INSN;  // R4, R5
    else if (is_fault && part_valid_i) src_o = SRC_PART;  // R3
    else if (is_addr)                  src_o = SRC_ADDR;  // R2
    else                               src_o = SRC_ZERO;  // R6
  end

  // R3: the portion address is chosen only when the caller flagged it.
  always_comb begin
    a_r3_part_needs_flag: assert (src_o != SRC_PART || part_valid_i);
  end
endmodule

// File: rtl/stval_insn_fmt.sv
module stval_insn_fmt #(
  parameter int SXLEN = 64,
  parameter int ILEN  = 32
) (
  input  logic [ILEN-1:0]  insn_i,
  input  logic             len32_i,
  output logic [SXLEN-1:0] val_o
);
  // Widest instruction image the register may receive.
  localparam int IW = (ILEN < SXLEN) ? ILEN : SXLEN;

  // Shortest of the real length, ILEN and SXLEN.
  function automatic int keep_bits(input logic l32);
    int act;
    act = l32 ? 32 : 16;
    return (act < IW) ? act : IW;
  endfunction

  int keep;

  always_comb begin
    keep  = keep_bits(len32_i);
    val_o = '0;                          // R5: upper bits cleared
    for (int i = 0; i < IW; i++) begin
      if (i < keep) val_o[i] = insn_i[i];
    end
  end
endmodule

// File: rtl/stval_warl.sv
module stval_warl #(
  parameter int SXLEN = 64,
  parameter int VA_W  = 39
) (
  input  logic [SXLEN-1:0] val_i,
  output logic [VA_W:0]    packed_o
);
  localparam int HI_W = SXLEN - VA_W + 1;  // bits VA_W-1 .. SXLEN-1

  function automatic logic [VA_W:0] squeeze(input logic [SXLEN-1:0] v);
    logic [HI_W-1:0] hi;
    logic            canon, up;
    hi    = v[SXLEN-1:VA_W-1];
    canon = (&hi) | ~(|hi);
    up    = canon ? v[VA_W-1] : ~v[VA_W-1];   // R8
    return {up, v[VA_W-1:0]};
  endfunction

  assign packed_o = squeeze(val_i);
endmodule

// File: rtl/stval_capture.sv
module stval_capture
  import stval_pkg::*;
#(
  parameter int SXLEN   = 64,
  parameter int ILEN    = 32,
  parameter int VA_W    = 39,
  parameter int CAUSE_W = 5,
  parameter int NCAUSE  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [SXLEN-1:0]   fault_va_i,
  input  logic [SXLEN-1:0]   part_va_i,
  input  logic               part_valid_i,
  input  logic [ILEN-1:0]    insn_i,
  input  logic               insn_len32_i,
  input  logic [NCAUSE-1:0]  info_en_i,
  input  logic               csr_we_i,
  input  logic [SXLEN-1:0]   csr_wdata_i,
  output logic [SXLEN-1:0]   csr_rdata_o
);
  localparam int ST_W  = VA_W + 1;
  localparam int EXT_W = SXLEN - VA_W;

  // Named internal events.
  logic             trap_load, csr_load, any_load;
  src_e             src;
  logic [SXLEN-1:0] insn_val, cand, next_val;
  logic [ST_W-1:0]  next_st, st_q;

  assign trap_load = trap_i;
  assign csr_load  = csr_we_i & ~trap_i;    // R10: trap wins
  assign any_load  = trap_load | csr_load;

  stval_src_sel #(.CAUSE_W(CAUSE_W), .NCAUSE(NCAUSE)) u_sel (
    .cause_i      (cause_i),
    .info_en_i    (info_en_i),
    .part_valid_i (part_valid_i),
    .src_o        (src)
  );

  stval_insn_fmt #(.SXLEN(SXLEN), .ILEN(ILEN)) u_fmt (
    .insn_i  (insn_i),
    .len32_i (insn_len32_i),
    .val_o   (insn_val)
  );

  always_comb begin
    unique case (src)
      SRC_ADDR: cand = fault_va_i;
      SRC_PART: cand = part_va_i;
      SRC_INSN: cand = insn_val;
      default:  cand = '0;
    endcase
    next_val = trap_load ? cand : csr_wdata_i;
  end

  stval_warl #(.SXLEN(SXLEN), .VA_W(VA_W)) u_warl (
    .val_i    (next_val),
    .packed_o (next_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_q <= '0;           // R1
    else if (any_load) st_q <= next_st;      // R11: hold otherwise
  end

  assign csr_rdata_o = {{EXT_W{st_q[ST_W-1]}}, st_q[VA_W-1:0]};

  // Sign-extension view of the fault address, used only by checks.
  logic fault_canon;
  assign fault_canon =
    (fault_va_i == {{EXT_W{fault_va_i[VA_W-1]}}, fault_va_i[VA_W-1:0]});

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_i && !csr_we_i) |=> $stable(csr_rdata_o));

  a_r9_csr_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && !trap_i) |=> csr_rdata_o[VA_W-1:0] == $past(csr_wdata_i[VA_W-1:0]));

  // R7 also lands here: a masked cause selects the zero source.
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && src == SRC_ZERO) |=> csr_rdata_o == '0);

  a_r2_canon_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && src == SRC_ADDR && fault_canon) |=> csr_rdata_o == $past(fault_va_i));

  a_r4_insn32: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && src == SRC_INSN && insn_len32_i) |=>
      csr_rdata_o == {{(SXLEN-ILEN){1'b0}}, $past(insn_i)});
endmodule

// File: tb/stval_capture_test.sv
`timescale 1ns/1ps
module stval_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_i = 1'b0;
  logic [4:0]  cause_i = '0;
  logic [63:0] fault_va_i = '0;
  logic [63:0] part_va_i = '0;
  logic        part_valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        insn_len32_i = 1'b0;
  logic [15:0] info_en_i = 16'hFFFF;
  logic        csr_we_i = 1'b0;
  logic [63:0] csr_wdata_i = '0;
  logic [63:0] csr_rdata_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;   // 250 MHz

  stval_capture uut (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .cause_i(cause_i),
    .fault_va_i(fault_va_i), .part_va_i(part_va_i), .part_valid_i(part_valid_i),
    .insn_i(insn_i), .insn_len32_i(insn_len32_i), .info_en_i(info_en_i),
    .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  cause;
    logic        pv;
    logic        l32;
    logic        en;
    logic [63:0] fva;
    logic [63:0] pva;
    logic [31:0] insn;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    // R2 load misaligned
    '{4'd2, 5'd4,  1'b0, 1'b1, 1'b1, 64'h0000_0000_1000_0003, 64'h0, 32'h0, 64'h0000_0000_1000_0003},
    // R6 ecall-range cause 8
    '{4'd6, 5'd8,  1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_1234, 64'h0, 32'h0, 64'h0},
    // R2 breakpoint, canonical upper-half address
    '{4'd2, 5'd3,  1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_C000_0010, 64'h0, 32'h0, 64'hFFFF_FFFF_C000_0010},
    // R6 cause 14
    '{4'd6, 5'd14, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_5678, 64'h0, 32'h0, 64'h0},
    // R3 load access fault, portion address
    '{4'd3, 5'd5,  1'b1, 1'b1, 1'b1, 64'h0000_0000_1000_0FFE, 64'h0000_0000_1000_1000, 32'h0, 64'h0000_0000_1000_1000},
    // R6 cause 20 (above 15)
    '{4'd6, 5'd20, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_9999, 64'h0, 32'h0, 64'h0},
    // R3 instruction page fault, portion address
    '{4'd3, 5'd12, 1'b1, 1'b1, 1'b1, 64'h0000_0000_8000_0FFE, 64'h0000_0000_8000_1000, 32'h0, 64'h0000_0000_8000_1000},
    // R7 breakpoint masked
    '{4'd7, 5'd3,  1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_4444, 64'h0, 32'h0, 64'h0},
    // R2 store page fault, no portion flag
    '{4'd2, 5'd15, 1'b0, 1'b1, 1'b1, 64'h0000_0000_2000_0000, 64'h0000_0000_0000_5555, 32'h0, 64'h0000_0000_2000_0000},
    // R7 illegal instruction masked
    '{4'd7, 5'd2,  1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 32'hDEAD_BEEF, 64'h0},
    // R3 store misaligned ignores portion flag
    '{4'd3, 5'd6,  1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_3001, 64'h0000_0000_0000_3008, 32'h0, 64'h0000_0000_0000_3001},
    // R4 illegal, 32-bit
    '{4'd4, 5'd2,  1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 32'hDEAD_BEEF, 64'h0000_0000_DEAD_BEEF},
    // R5 illegal, 16-bit
    '{4'd5, 5'd2,  1'b0, 1'b0, 1'b1, 64'h0, 64'h0, 32'hDEAD_BEEF, 64'h0000_0000_0000_BEEF},
    // R8 non-canonical, bit 38 clear -> upper filled with ones
    '{4'd8, 5'd13, 1'b0, 1'b1, 1'b1, 64'h1234_0000_0000_1000, 64'h0, 32'h0, 64'hFFFF_FF80_0000_1000},
    // R8 non-canonical, bit 38 set -> upper filled with zeros
    '{4'd8, 5'd7,  1'b0, 1'b1, 1'b1, 64'h8000_0040_0000_0000, 64'h0, 32'h0, 64'h0000_0040_0000_0000},
    // R8 non-canonical already in stored form
    '{4'd8, 5'd1,  1'b0, 1'b1, 1'b1, 64'h0000_0040_0000_1000, 64'h0, 32'h0, 64'h0000_0040_0000_1000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic tr, input logic [4:0] c, input logic pv,
                       input logic l32, input logic [15:0] en,
                       input logic [63:0] f, input logic [63:0] p,
                       input logic [31:0] ins, input logic we,
                       input logic [63:0] wd);
    @(negedge clk);
    trap_i = tr; cause_i = c; part_valid_i = pv; insn_len32_i = l32;
    info_en_i = en; fault_va_i = f; part_va_i = p; insn_i = ins;
    csr_we_i = we; csr_wdata_i = wd;
    @(negedge clk);
    trap_i = 1'b0; csr_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", csr_rdata_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", csr_rdata_o, 64'h0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      logic [15:0] m;
      v = TBL[k];
      m = v.en ? 16'hFFFF : ~(16'h1 << v.cause[3:0]);
      pulse(1'b1, v.cause, v.pv, v.l32, m, v.fva, v.pva, v.insn, 1'b0, 64'h0);
      check($sformatf("R%0d vector %0d", v.req, k), csr_rdata_o, v.exp);
    end

    // R11: idle with moving data inputs
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      fault_va_i = 64'hABCD_0000_0000_0000 + 64'(k); csr_wdata_i = 64'h77; cause_i = 5'd4;
      check("R11 hold", csr_rdata_o, 64'h0000_0040_0000_1000);
    end

    // R9: canonical write kept, non-canonical legalized
    pulse(1'b0, 5'd0, 1'b0, 1'b1, 16'hFFFF, 64'h0, 64'h0, 32'h0, 1'b1, 64'hFFFF_FFFF_FFFF_F000);
    check("R9 canonical write", csr_rdata_o, 64'hFFFF_FFFF_FFFF_F000);
    pulse(1'b0, 5'd0, 1'b0, 1'b1, 16'hFFFF, 64'h0, 64'h0, 32'h0, 1'b1, 64'h00F0_0000_0000_0ABC);
    check("R9 legalized write", csr_rdata_o, 64'hFFFF_FF80_0000_0ABC);

    // R10: trap (zero cause) and write together
    pulse(1'b1, 5'd9, 1'b0, 1'b1, 16'hFFFF, 64'h0, 64'h0, 32'h0, 1'b1, 64'h0000_0000_0000_0077);
    check("R10 trap zero wins", csr_rdata_o, 64'h0);
    pulse(1'b1, 5'd4, 1'b0, 1'b1, 16'hFFFF, 64'h0000_0000_0000_0100, 64'h0, 32'h0, 1'b1, 64'h0000_0000_0000_0077);
    check("R10 trap addr wins", csr_rdata_o, 64'h0000_0000_0000_0100);

    // R1: reset during operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", csr_rdata_o, 64'h0);
    rst_n = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule